// File: doc/BRIEF.md
# I2C SCL timing generator

This block paces the serial clock of an I2C master. It alternates between a low phase and a high phase of programmed length and drives the SCL output from that phase. It also marks two points in each low phase for the byte engine that sits beside it. A shift strobe marks the cycle in which SCL goes low. A hold-done strobe marks the cycle after which SDA may change.

Two timing schemes are available. In the standard scheme a single 9-bit divider N sets both phases. N is split across a 7-bit low field and a 2-bit high field. Each phase lasts 2N source clocks, so the SCL period is 4N clocks. In the fast scheme the low phase, the high phase and the data hold each have their own count. The low and high registers hold half of the wanted clock count. The hold register holds plain clocks. Software picks the register values for a given source clock and bus rate.

An external device may stretch the clock. The high phase does not begin to count while the sensed SCL line still reads low.

Top module: `i2c_scl_timer`

## Requirements
- R1: While en_i is low, scl_o is 1 in that same cycle, and shift_o and hold_done_o are 0. The phase counter is cleared, so after en_i rises SCL first stays high for one full high phase and then falls.
- R2: With fast_i = 0 the divider is N = {div_hi_i, div_lo_i}, with div_hi_i as bits 8:7. Each low phase and each high phase lasts 2N clocks, giving a period of 4N.
- R3: With fast_i = 1 a low phase lasts 2 × low_cnt_i clocks and a high phase lasts 2 × high_cnt_i clocks.
- R4: A divider or phase count of zero acts as one, so that phase lasts 2 clocks.
- R5: shift_o is high for exactly one cycle per low phase: the first cycle in which scl_o is 0.
- R6: hold_done_o pulses once, k cycles after the shift_o cycle. In fast mode k is hold_i; in standard mode k is N (taken as 1 when N is 0). If k is not less than the low-phase length, there is no pulse.
- R7: In the high phase the counter does not start while scl_in_i is 0. A stretch of S cycles lengthens that high phase by S cycles.
- R8: fast_i selects the timing scheme: in standard mode the fast-mode registers have no effect, and in fast mode the divider fields have no effect. Configuration inputs are to be changed only while en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the clock generator |
| fast_i | input | 1 | 1 selects the fast scheme, 0 the standard scheme |
| div_lo_i | input | 7 | Divider N, bits 6:0 |
| div_hi_i | input | 2 | Divider N, bits 8:7 |
| low_cnt_i | input | 8 | Fast low phase, half the clock count |
| high_cnt_i | input | 8 | Fast high phase, half the clock count |
| hold_i | input | 8 | Fast data hold, in clocks after SCL falls |
| scl_in_i | input | 1 | Sensed SCL line level |
| scl_o | output | 1 | SCL drive: 1 releases the line, 0 pulls it low |
| shift_o | output | 1 | Strobe in the first SCL-low cycle |
| hold_done_o | output | 1 | Strobe at the end of the SDA hold |

## Verification
The phase register changes on a clock edge, so scl_o, shift_o and hold_done_o are read just after each falling edge. Phase lengths are counted in those samples. The shift strobe must appear in the first low sample. The hold strobe must appear exactly k samples later, where k is computed in the bench from the mode and the register values. The release of SCL when the block is disabled depends on no register, so it is checked in the same half cycle in which en_i drops. A stretch is applied at the first high sample. The bench then expects the high phase to last the stretch length plus the programmed high length.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;
endpackage

// File: rtl/scl_len_sel.sv
module scl_len_sel #(
  parameter int DIV_LO_W = 7,
  parameter int DIV_HI_W = 2,
  parameter int FREG_W   = 8,
  parameter int HOLD_W   = 8,
  parameter int CNT_W    = 10
) (
  input  logic                fast_i,
  input  logic [DIV_LO_W-1:0] div_lo_i,
  input  logic [DIV_HI_W-1:0] div_hi_i,
  input  logic [FREG_W-1:0]   low_cnt_i,
  input  logic [FREG_W-1:0]   high_cnt_i,
  input  logic [HOLD_W-1:0]   hold_i,
  output logic [CNT_W-1:0]    low_len_o,
  output logic [CNT_W-1:0]    high_len_o,
  output logic [CNT_W-1:0]    hold_len_o
);
  localparam int NW = DIV_LO_W + DIV_HI_W;

  logic [NW-1:0]     n_raw, n_c;
  logic [FREG_W-1:0] lo_c, hi_c;
  logic [CNT_W-1:0]  std_len, f_lo_len, f_hi_len;

  always_comb begin
    n_raw    = {div_hi_i, div_lo_i};
    // zero counts run as one (R4)
    n_c      = (n_raw == '0) ? NW'(1) : n_raw;
    lo_c     = (low_cnt_i == '0) ? FREG_W'(1) : low_cnt_i;
    hi_c     = (high_cnt_i == '0) ? FREG_W'(1) : high_cnt_i;
    std_len  = CNT_W'({n_c, 1'b0});
    f_lo_len = CNT_W'({lo_c, 1'b0});
    f_hi_len = CNT_W'({hi_c, 1'b0});
    if (fast_i) begin
      low_len_o  = f_lo_len;
      high_len_o = f_hi_len;
      hold_len_o = CNT_W'(hold_i);
    end else begin
      low_len_o  = std_len;
      high_len_o = std_len;
      hold_len_o = CNT_W'(n_c);
    end
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import i2c_scl_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             scl_in_i,
  input  logic [CNT_W-1:0] low_len_i,
  input  logic [CNT_W-1:0] high_len_i,
  output scl_phase_e       ph_o,
  output logic [CNT_W-1:0] cnt_o
);
  scl_phase_e       ph_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
    end else if (!en_i) begin
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
    end else if (ph_q == PH_LOW) begin
      if (cnt_q >= low_len_i - CNT_W'(1)) begin
        ph_q  <= PH_HIGH;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else begin
      if (cnt_q == '0 && !scl_in_i) begin
        cnt_q <= '0;  // line still held low elsewhere
      end else if (cnt_q >= high_len_i - CNT_W'(1)) begin
        ph_q  <= PH_LOW;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign ph_o  = ph_q;
  assign cnt_o = cnt_q;

  p_off_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ph_q == PH_HIGH && cnt_q == '0));

  // R2 and R3: a low phase ends when its count is reached
  p_low_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ph_q == PH_LOW && cnt_q >= low_len_i - CNT_W'(1))
      |=> (ph_q == PH_HIGH && cnt_q == '0));

  p_high_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ph_q == PH_HIGH && scl_in_i && cnt_q >= high_len_i - CNT_W'(1))
      |=> (ph_q == PH_LOW && cnt_q == '0));

  p_stretch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ph_q == PH_HIGH && cnt_q == '0 && !scl_in_i)
      |=> (ph_q == PH_HIGH && cnt_q == '0));
endmodule

// File: rtl/scl_hold_det.sv
module scl_hold_det
  import i2c_scl_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  scl_phase_e       ph_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] hold_len_i,
  output logic             shift_o,
  output logic             hold_done_o
);
  logic in_low;

  always_comb begin
    in_low      = en_i && (ph_i == PH_LOW);
    shift_o     = in_low && (cnt_i == '0);
    hold_done_o = in_low && (cnt_i == hold_len_i);
  end

  p_shift_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |=> !shift_o);

  p_hold_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_done_o |-> (ph_i == PH_LOW && en_i));
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_pkg::*;
#(
  parameter int DIV_LO_W = 7,
  parameter int DIV_HI_W = 2,
  parameter int FREG_W   = 8,
  parameter int HOLD_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                fast_i,
  input  logic [DIV_LO_W-1:0] div_lo_i,
  input  logic [DIV_HI_W-1:0] div_hi_i,
  input  logic [FREG_W-1:0]   low_cnt_i,
  input  logic [FREG_W-1:0]   high_cnt_i,
  input  logic [HOLD_W-1:0]   hold_i,
  input  logic                scl_in_i,
  output logic                scl_o,
  output logic                shift_o,
  output logic                hold_done_o
);
  localparam int NW    = DIV_LO_W + DIV_HI_W;
  localparam int MW0   = (NW > FREG_W) ? NW : FREG_W;
  localparam int MW    = (MW0 > HOLD_W) ? MW0 : HOLD_W;
  localparam int CNT_W = MW + 1;

  logic [CNT_W-1:0] low_len, high_len, hold_len, cnt;
  scl_phase_e       ph;

  scl_len_sel #(
    .DIV_LO_W(DIV_LO_W), .DIV_HI_W(DIV_HI_W), .FREG_W(FREG_W),
    .HOLD_W(HOLD_W), .CNT_W(CNT_W)
  ) u_len (
    .fast_i(fast_i), .div_lo_i(div_lo_i), .div_hi_i(div_hi_i),
    .low_cnt_i(low_cnt_i), .high_cnt_i(high_cnt_i), .hold_i(hold_i),
    .low_len_o(low_len), .high_len_o(high_len), .hold_len_o(hold_len)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) u_ph (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .scl_in_i(scl_in_i),
    .low_len_i(low_len), .high_len_i(high_len), .ph_o(ph), .cnt_o(cnt)
  );

  scl_hold_det #(.CNT_W(CNT_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ph_i(ph), .cnt_i(cnt),
    .hold_len_i(hold_len), .shift_o(shift_o), .hold_done_o(hold_done_o)
  );

  assign scl_o = !en_i || (ph == PH_HIGH);

  p_fall_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_o) |-> shift_o);

  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!shift_o && !hold_done_o));
endmodule

// File: tb/i2c_scl_timer_bench.sv
module i2c_scl_timer_bench;
  localparam int CLK_P = 10;
  localparam int LIM   = 4000;

  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0, fast = 1'b0, stretch = 1'b0;
  logic [6:0] div_lo = '0;
  logic [1:0] div_hi = '0;
  logic [7:0] lo_r = '0, hi_r = '0, hold_r = '0;
  logic       scl, shift, hdone, scl_in;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;
  assign scl_in = scl && !stretch;

  i2c_scl_timer u_i2c_scl_timer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fast_i(fast),
    .div_lo_i(div_lo), .div_hi_i(div_hi), .low_cnt_i(lo_r),
    .high_cnt_i(hi_r), .hold_i(hold_r), .scl_in_i(scl_in),
    .scl_o(scl), .shift_o(shift), .hold_done_o(hdone)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int plen(input int v);
    return 2 * ((v == 0) ? 1 : v);
  endfunction

  task automatic run_cfg(input bit fst, input int n, input int lo, input int hi,
                         input int hd, input int st);
    int ll, hl, h, cnt, hold_at, shifts, exp_hold;
    string rq;
    if (fst) begin
      ll = plen(lo); hl = plen(hi); h = hd; rq = "R3";
    end else begin
      ll = plen(n); hl = ll; h = (n == 0) ? 1 : n; rq = "R2";
    end
    @(negedge clk);
    en = 1'b0; stretch = 1'b0;
    fast = fst; div_lo = n[6:0]; div_hi = n[8:7];
    lo_r = lo[7:0]; hi_r = hi[7:0]; hold_r = hd[7:0];
    @(negedge clk);
    en = 1'b1; #1;
    cnt = 0;
    while (scl && cnt < LIM) begin cnt++; @(negedge clk); #1; end
    chk(cnt == hl, "R1", "first high after enable", cnt, hl);
    chk(shift == 1'b1, "R5", "shift at first low cycle", int'(shift), 1);
    cnt = 0; hold_at = -1; shifts = 0;
    while (!scl && cnt < LIM) begin
      if (hdone) hold_at = cnt;
      if (shift) shifts++;
      cnt++; @(negedge clk); #1;
    end
    chk(cnt == ll, rq, "low phase length", cnt, ll);
    chk(shifts == 1, "R5", "shift pulses per low phase", shifts, 1);
    exp_hold = (h < ll) ? h : -1;
    chk(hold_at == exp_hold, "R6", "hold_done offset", hold_at, exp_hold);
    cnt = 1;
    stretch = (st > 0);
    repeat (st) begin @(negedge clk); #1; cnt++; end
    stretch = 1'b0;
    @(negedge clk); #1;
    while (scl && cnt < LIM) begin cnt++; @(negedge clk); #1; end
    chk(cnt == st + hl, (st > 0) ? "R7" : rq, "high phase length", cnt, st + hl);
    en = 1'b0; #1;
    chk(scl && !shift && !hdone, "R1", "release on disable", int'(scl), 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 3);
    chk(scl && !shift && !hdone, "R1", "reset outputs", int'(scl), 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(scl && !shift && !hdone, "R1", "idle outputs", int'(scl), 1);
    // standard divider sweep (R2), clamp (R4), upper field (R2)
    for (int n = 1; n <= 6; n++) run_cfg(1'b0, n, 0, 0, 0, 0);
    run_cfg(1'b0, 0, 0, 0, 0, 0);
    run_cfg(1'b0, 130, 0, 0, 0, 0);
    run_cfg(1'b0, 384, 0, 0, 0, 0);
    // R8: fast registers ignored in standard mode and vice versa
    run_cfg(1'b0, 3, 42, 28, 22, 0);
    run_cfg(1'b1, 77, 3, 5, 1, 0);
    // fast mode shapes (R3), hold (R6), zero clamp (R4)
    run_cfg(1'b1, 0, 42, 28, 22, 0);
    run_cfg(1'b1, 0, 16, 12, 13, 0);
    run_cfg(1'b1, 0, 10, 7, 11, 0);
    run_cfg(1'b1, 0, 0, 0, 0, 0);
    run_cfg(1'b1, 0, 4, 4, 9, 0);
    run_cfg(1'b1, 0, 2, 3, 4, 0);
    run_cfg(1'b1, 0, 2, 3, 3, 0);
    // stretch (R7)
    run_cfg(1'b1, 0, 3, 2, 1, 3);
    run_cfg(1'b0, 2, 0, 0, 0, 5);
    run_cfg(1'b1, 0, 1, 1, 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule